// File: doc/BRIEF.md
# Skip and Two-Word Instruction Sequencer

This block is the issue control of a core that runs 16-bit program words through a single-cycle pipeline. Each cycle it is handed the word at the current program counter. With it come the condition result of that word and a redirect request from the branch logic. It decides whether the slot executes as a real instruction, serves as the operand word of a two-word instruction, or is squashed into a no-operation. It also advances or reloads the program counter. Every instruction ends with a one-cycle completion strobe that carries the number of cycles it took.

A conditional-skip instruction whose condition holds squashes the next instruction. That instruction may be one word or two words long. The sequencer classifies the word it is squashing: when that word opens a two-word instruction, the trailing word is squashed as well. A skip over a short instruction therefore costs two cycles, and a skip over a long one costs three. A trailing word reached on its own, for example as a jump target, runs as a no-operation, so every program location is harmless to execute. The datapath gets write strobes that are held low in every squashed slot.

Top module: `skip_seq`

## Requirements
- R1: While reset is low and right after it, the program counter reads 0 and the first slot starts a new instruction.
- R2: An ordinary one-word instruction issues with `issueValid` high, completes in 1 cycle, and the next instruction is at PC+1.
- R3: The skip-class words are compare (top 7 bits 0110000, 0110001, 0110010), zero test (0110011), bit test (top 4 bits 1010 or 1011) and the counting skips (top 6 bits 001011, 001111, 010011, 010010). When the condition is false, such a word takes 1 cycle and the next PC is PC+1. Near neighbours such as 011010 and 001010 are ordinary words.
- R4: A skip-class word with a true condition, followed by a one-word instruction, squashes that following slot. It takes 2 cycles and continues at PC+2.
- R5: A skip-class word with a true condition, followed by a word whose top 4 bits are 1100, squashes both words of that instruction. It takes 3 cycles and continues at PC+3.
- R6: A word with top bits 1100 issues and opens a two-word instruction. The following slot has `operandSlot` high, `issueValid` low and `regWriteEn` high. The instruction takes 2 cycles and continues at PC+2.
- R7: A word with top bits 1111 reached on its own runs as a no-operation: no issue, no writes, 1 cycle, next PC+1.
- R8: A taken branch on an issued ordinary word loads `branchTarget` into the PC. The next slot is a refill bubble in which the PC does not move. The branch takes 2 cycles.
- R9: In every squashed or bubble slot `issueValid`, `regWriteEn` and `flagWriteEn` are low.
- R10: In an issue slot, skip-class words and two-word opening words raise no `flagWriteEn`. Compare, zero-test, bit-test and two-word opening words raise no `regWriteEn`. Counting skips and ordinary words raise `regWriteEn`, and ordinary words raise `flagWriteEn`.
- R11: `instrDone` is high exactly in the last cycle of each instruction, and `instrCycles` then holds that instruction's cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrWord | input | WORD_W | Program word at the current PC |
| testTrue | input | 1 | Condition result of the current word |
| branchTaken | input | 1 | Redirect request from branch logic |
| branchTarget | input | PC_W | Redirect address |
| pc | output | PC_W | Program counter (word address) |
| issueValid | output | 1 | Slot executes as a real instruction |
| operandSlot | output | 1 | Slot carries the second word of a two-word instruction |
| regWriteEn | output | 1 | Register-file write permitted this cycle |
| flagWriteEn | output | 1 | Status-flag write permitted this cycle |
| instrDone | output | 1 | Last cycle of the current instruction |
| instrCycles | output | CNT_W | Cycle count of the instruction ending now |

## Verification
The delicate overlap occurs in the first squashed slot after a taken skip. In that one cycle the squash of the skip and the decode of a two-word opening word take place together, and the outcome decides whether one or two slots are lost. The bench provokes this overlap by sweeping every skip-class word and several near-miss words against both condition values and both lengths of the following instruction. For each case it predicts the cycle count, the squashed slots and the landing PC arithmetically. A bound property also checks that the trailing word is squashed and is never taken as an operand.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;

  // Role of the slot currently being presented
  typedef enum logic [2:0] {
    SL_EXEC,    // a new instruction starts here
    SL_SKIP1,   // first word squashed by a taken skip
    SL_SKIP2,   // trailing word of a skipped two-word instruction
    SL_OPER,    // operand word of an executing two-word instruction
    SL_REFILL   // bubble after a redirect
  } slotKind_t;

  typedef struct packed {
    logic skipClass;
    logic noRegWr;
    logic twoFirst;
    logic twoSecond;
  } wordClass_t;

  typedef struct packed {
    logic pcLoad;
    logic pcAdvance;
    logic cntClear;
  } dpStrobe_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import skip_seq_pkg::*;
(
  input  logic [5:0]  opHi,
  output wordClass_t  cls
);

  logic cmpTest, bitTest, countSkip;

  always_comb begin
    cmpTest   = (opHi[5:1] == 5'b01100);
    bitTest   = (opHi[5:3] == 3'b101);
    countSkip = (opHi == 6'b001011) || (opHi == 6'b001111) ||
                (opHi == 6'b010011) || (opHi == 6'b010010);
    cls.skipClass = cmpTest | bitTest | countSkip;
    cls.noRegWr   = cmpTest | bitTest;
    cls.twoFirst  = (opHi[5:2] == 4'b1100);
    cls.twoSecond = (opHi[5:2] == 4'b1111);
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import skip_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  wordClass_t cls,
  input  logic       testTrue,
  input  logic       branchTaken,
  output logic       issueValid,
  output logic       operandSlot,
  output logic       regWriteEn,
  output logic       flagWriteEn,
  output logic       instrDone,
  output dpStrobe_t  strobe
);

  slotKind_t slotQ, slotNext;

  always_comb begin
    slotNext         = SL_EXEC;
    issueValid       = 1'b0;
    operandSlot      = 1'b0;
    strobe.pcLoad    = 1'b0;
    strobe.pcAdvance = 1'b1;
    case (slotQ)
      SL_EXEC: begin
        if (!cls.twoSecond) begin
          issueValid = 1'b1;
          if (cls.twoFirst) begin
            slotNext = SL_OPER;
          end else if (cls.skipClass) begin
            if (testTrue) slotNext = SL_SKIP1;
          end else if (branchTaken) begin
            slotNext         = SL_REFILL;
            strobe.pcLoad    = 1'b1;
            strobe.pcAdvance = 1'b0;
          end
        end
      end
      SL_SKIP1: begin
        if (cls.twoFirst) slotNext = SL_SKIP2;
      end
      SL_SKIP2: ;
      SL_OPER:   operandSlot = 1'b1;
      SL_REFILL: strobe.pcAdvance = 1'b0;
      default: ;
    endcase
    regWriteEn      = (issueValid & ~cls.noRegWr & ~cls.twoFirst) | operandSlot;
    flagWriteEn     = issueValid & ~cls.skipClass & ~cls.twoFirst;
    instrDone       = (slotNext == SL_EXEC);
    strobe.cntClear = instrDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotQ <= SL_EXEC;
    else       slotQ <= slotNext;
  end

endmodule

// File: rtl/seq_dp.sv
module seq_dp
  import skip_seq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [PC_W-1:0]  branchTarget,
  output logic [PC_W-1:0]  pc,
  output logic [CNT_W-1:0] instrCycles
);

  logic [CNT_W-1:0] cycCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= '0;
      cycCnt <= '0;
    end else begin
      if (strobe.pcLoad)         pc <= branchTarget;
      else if (strobe.pcAdvance) pc <= pc + PC_W'(1);
      if (strobe.cntClear) cycCnt <= '0;
      else                 cycCnt <= cycCnt + CNT_W'(1);
    end
  end

  assign instrCycles = cycCnt + CNT_W'(1);

endmodule

// File: rtl/skip_seq.sv
module skip_seq
  import skip_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PC_W   = 12,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              testTrue,
  input  logic              branchTaken,
  input  logic [PC_W-1:0]   branchTarget,
  output logic [PC_W-1:0]   pc,
  output logic              issueValid,
  output logic              operandSlot,
  output logic              regWriteEn,
  output logic              flagWriteEn,
  output logic              instrDone,
  output logic [CNT_W-1:0]  instrCycles
);

  localparam int OP_MSB = WORD_W - 1;

  wordClass_t wordCls;
  dpStrobe_t  dpStb;

  seq_decode u_decode (
    .opHi (instrWord[OP_MSB -: 6]),
    .cls  (wordCls)
  );

  seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cls         (wordCls),
    .testTrue    (testTrue),
    .branchTaken (branchTaken),
    .issueValid  (issueValid),
    .operandSlot (operandSlot),
    .regWriteEn  (regWriteEn),
    .flagWriteEn (flagWriteEn),
    .instrDone   (instrDone),
    .strobe      (dpStb)
  );

  seq_dp #(.PC_W(PC_W), .CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (dpStb),
    .branchTarget (branchTarget),
    .pc           (pc),
    .instrCycles  (instrCycles)
  );

endmodule

// File: rtl/skip_seq_chk.sv
module skip_seq_chk #(
  parameter int WORD_W = 16,
  parameter int PC_W   = 12,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] instrWord,
  input logic              testTrue,
  input logic              branchTaken,
  input logic [PC_W-1:0]   pc,
  input logic              issueValid,
  input logic              operandSlot,
  input logic              regWriteEn,
  input logic              flagWriteEn,
  input logic              instrDone,
  input logic [CNT_W-1:0]  instrCycles
);

  localparam int MSB = WORD_W - 1;

  logic [5:0] hi;
  logic isSkipWord, isOpen, isTrail;

  always_comb begin
    hi         = instrWord[MSB -: 6];
    isSkipWord = (hi[5:1] == 5'b01100) || (hi[5:3] == 3'b101) ||
                 (hi == 6'b001011) || (hi == 6'b001111) ||
                 (hi == 6'b010011) || (hi == 6'b010010);
    isOpen     = (hi[5:2] == 4'b1100);
    isTrail    = (hi[5:2] == 4'b1111);
  end

  // R9
  squash_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!issueValid && !operandSlot) |-> (!regWriteEn && !flagWriteEn));

  // R4
  skip_squash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && isSkipWord && testTrue) |=> (!issueValid && !operandSlot));

  // R5
  skip_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!issueValid && isOpen && $past(issueValid && isSkipWord && testTrue))
      |=> (!issueValid && !operandSlot));

  // R6
  operand_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && isOpen) |=> (operandSlot && !issueValid));

  // R7
  trail_noissue_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(issueValid && isTrail));

  // R10
  skip_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && isSkipWord) |-> !flagWriteEn);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !branchTaken) |=> ((pc - $past(pc)) == PC_W'(1)));

  // R11
  cycles_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |-> (instrCycles >= CNT_W'(1) && instrCycles <= CNT_W'(3)));

endmodule

bind skip_seq skip_seq_chk #(.WORD_W(WORD_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .instrWord   (instrWord),
  .testTrue    (testTrue),
  .branchTaken (branchTaken),
  .pc          (pc),
  .issueValid  (issueValid),
  .operandSlot (operandSlot),
  .regWriteEn  (regWriteEn),
  .flagWriteEn (flagWriteEn),
  .instrDone   (instrDone),
  .instrCycles (instrCycles)
);

// File: tb/tb_skip_seq.sv
module tb_skip_seq;

  localparam int WORD_W = 16;
  localparam int PC_W   = 12;
  localparam int CNT_W  = 3;
  localparam int NW     = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic condBit = 1'b0;
  logic brBit = 1'b0;
  logic [WORD_W-1:0] mem [8];
  logic [PC_W-1:0] pc;
  logic issueValid, operandSlot, regWriteEn, flagWriteEn, instrDone;
  logic [CNT_W-1:0] instrCycles;
  logic [WORD_W-1:0] instrWord;
  logic testTrue, branchTaken;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  assign instrWord   = mem[pc[2:0]];
  assign testTrue    = condBit && (pc == '0);
  assign branchTaken = brBit && (pc == '0);

  skip_seq #(.WORD_W(WORD_W), .PC_W(PC_W), .CNT_W(CNT_W)) dut (
    .clk, .rstN, .instrWord, .testTrue, .branchTaken,
    .branchTarget (PC_W'(5)),
    .pc, .issueValid, .operandSlot, .regWriteEn, .flagWriteEn,
    .instrDone, .instrCycles
  );

  // Word under test and its class: 0 ordinary, 1 compare/bit test,
  // 2 counting skip, 3 two-word opener, 4 lone trailing word
  logic [15:0] words [NW] = '{16'h0E12, 16'h6A12, 16'h2A12, 16'h6212, 16'h6412,
                              16'h6012, 16'h6612, 16'hA212, 16'hB212, 16'h2E12,
                              16'h3E12, 16'h4E12, 16'h4A12, 16'hC012, 16'hF012};
  int classOf [NW] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 2, 2, 2, 2, 3, 4};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runCase(logic [15:0] w, int cls, bit cond, bit bTwo, bit br);
    int expCyc, expNext, gotCyc;
    string tag;
    mem[0] = w;
    mem[1] = bTwo ? 16'hC034 : 16'h0000;
    mem[2] = bTwo ? 16'hF056 : 16'h0000;
    for (int i = 3; i < 8; i++) mem[i] = 16'h0000;
    condBit = cond;
    brBit   = br;
    @(negedge clk) rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", int'(pc), 0);
    rstN = 1'b1;
    #1;
    // expected cost and landing point
    if (br) begin expCyc = 2; expNext = 5; tag = "R8"; end
    else case (cls)
      0: begin expCyc = 1; expNext = 1; tag = "R2"; end
      1, 2: begin
        if (!cond)     begin expCyc = 1; expNext = 1; tag = "R3"; end
        else if (bTwo) begin expCyc = 3; expNext = 3; tag = "R5"; end
        else           begin expCyc = 2; expNext = 2; tag = "R4"; end
      end
      3: begin expCyc = 2; expNext = 2; tag = "R6"; end
      default: begin expCyc = 1; expNext = 1; tag = "R7"; end
    endcase
    // first slot: R10 write strobes, R7 lone trailing word
    chk(cls == 4 ? "R7 issue" : "R2 issue", int'(issueValid), int'(cls != 4));
    chk("R10 regWriteEn", int'(regWriteEn), int'(cls == 0 || cls == 2));
    chk("R10 flagWriteEn", int'(flagWriteEn), int'(cls == 0));
    gotCyc = 0;
    for (int c = 1; c <= 6; c++) begin
      if (c > 1) begin
        chk("R9 issue in squash", int'(issueValid), 0);
        chk("R9 flag in squash", int'(flagWriteEn), 0);
        chk("R6 operandSlot", int'(operandSlot), int'(cls == 3 && c == 2));
        chk("R9 reg in squash", int'(regWriteEn), int'(cls == 3 && c == 2));
        if (br) chk("R8 pc held", int'(pc), 5);
      end
      if (instrDone) begin gotCyc = c; break; end
      @(posedge clk);
      @(negedge clk);
    end
    chk({tag, " cycles"}, gotCyc, expCyc);
    chk("R11 instrCycles", int'(instrCycles), expCyc);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " next pc"}, int'(pc), expNext);
    chk({tag, " next issue"}, int'(issueValid), int'(mem[expNext[2:0]][15:12] != 4'hF));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 16'h0000;
    for (int k = 0; k < NW; k++)
      for (int cnd = 0; cnd < 2; cnd++)
        for (int two = 0; two < 2; two++)
          runCase(words[k], classOf[k], cnd[0], two[0], 1'b0);
    runCase(16'h0E12, 0, 1'b0, 1'b0, 1'b1);
    runCase(16'h0000, 0, 1'b0, 1'b1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule